// File: doc/BRIEF.md
# Programmable Inter-Frame Gap Enforcer

This block guards the transmit side of a 10/100 Ethernet MAC on a nibble-wide media-independent interface. It keeps the line idle for at least a programmed number of bit times between the last nibble of one frame and the first nibble of the next. The transmitter reports its transmit-enable line. The frame source raises a request. The block answers with a registered grant, and the transmitter may start a frame only in the cycle after it sees that grant.

The gap comes from a 3-bit code. Each step of the code shortens the gap by 8 bit times. In half-duplex operation the gap is clamped at a 64-bit-time floor. The block counts in clock cycles. By default one clock cycle is one nibble, which is 4 bit times. Two parameters give the number of clock cycles per nibble at each speed, so the same logic also works on a clock faster than the nibble rate. The code, duplex and speed are sampled once, at the end of a frame, and stay fixed for that gap.

Top module: `ifg_enforcer`

## Requirements
- R1: In full duplex, gap code c (0 to 7) gives a gap of 96 - 8*c bit times: 96 for code 0 and 40 for code 7. That is (24 - 2*c) nibbles.
- R2: In half duplex (half_duplex_i = 1), codes 0 to 4 give the same gap as in R1. Codes 5, 6 and 7 each give 64 bit times (16 nibbles).
- R3: When speed_100_i = 0 (10 Mb/s), each nibble of the gap lasts CYC_PER_NIB_10 clock cycles. When speed_100_i = 1 (100 Mb/s), it lasts CYC_PER_NIB_100 clock cycles.
- R4: A gap of G cycles starts at the first clock edge where tx_en_i is sampled low after being sampled high. grant_o rises after the G-th such edge. A transmitter that answers the grant can therefore reassert tx_en_i after exactly G idle cycles, and never earlier.
- R5: grant_o is low in every cycle that follows an edge where tx_en_i was sampled high.
- R6: The code, duplex and speed are sampled at the edge where tx_en_i falls. A change to them while a gap is counting does not alter that gap. The new values apply to the next gap.
- R7: After reset no gap is owed. With tx_req_i held high, grant_o is high one cycle after reset is released.
- R8: grant_o is high only when tx_req_i was high at the edge before. Once the gap has elapsed, grant_o follows tx_req_i with a delay of one cycle.
- R9: While rst is high, and in the cycle after any edge where rst was sampled high, grant_o is low. Reset also abandons any gap that is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst | input | 1 | Synchronous active-high reset |
| gap_code_i | input | 3 | Gap code: 0 gives 96 bit times, 7 gives 40 bit times |
| half_duplex_i | input | 1 | 1 = half duplex (64-bit-time floor applies) |
| speed_100_i | input | 1 | 0 = 10 Mb/s, 1 = 100 Mb/s |
| tx_en_i | input | 1 | Transmit enable from the transmitter |
| tx_req_i | input | 1 | Request to send from the frame source |
| grant_o | output | 1 | Registered permission to start the next frame |

## Verification
The bench builds the block with 3 cycles per nibble at 10 Mb/s and 1 cycle per nibble at 100 Mb/s. Because the two speeds then differ, a multiplier that picks the wrong speed changes the measured gap. Gaps in the table run from 10 to 72 cycles. The bench measures the idle time for all eight codes in both duplex modes, with the speed alternating between entries. It also covers a configuration change in the middle of a gap, a request held low past the end of a gap, and a reset during a gap.

// File: rtl/ifg_pkg.sv
package ifg_pkg;
  localparam int GAP_CODE_W = 3;
  localparam int NCODES     = 1 << GAP_CODE_W;
  typedef logic [GAP_CODE_W-1:0] gap_code_t;
endpackage

// File: rtl/ifg_fall_detect.sv
module ifg_fall_detect (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  output logic fall_o
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= en_i;
  end

  // Last nibble was in the previous cycle; this cycle is the first idle one.
  assign fall_o = en_q & ~en_i;
endmodule

// File: rtl/ifg_gap_decode.sv
module ifg_gap_decode
  import ifg_pkg::*;
#(
  parameter int BASE_BITS       = 96,
  parameter int STEP_BITS       = 8,
  parameter int HD_FLOOR_CODE   = 4,
  parameter int BITS_PER_NIB    = 4,
  parameter int CYC_PER_NIB_10  = 1,
  parameter int CYC_PER_NIB_100 = 1,
  parameter int CW              = 5
) (
  input  gap_code_t       code_i,
  input  logic            half_i,
  input  logic            speed_i,
  output logic [CW-1:0]   cycles_o
);
  localparam int MAX_NIB = BASE_BITS / BITS_PER_NIB;
  localparam int NW      = $clog2(MAX_NIB + 1);
  localparam int MAX_MUL = (CYC_PER_NIB_10 > CYC_PER_NIB_100) ? CYC_PER_NIB_10 : CYC_PER_NIB_100;
  localparam int MW      = $clog2(MAX_MUL + 1);

  logic [NW-1:0] fd_nib [NCODES];
  logic [NW-1:0] hd_nib [NCODES];
  logic [NW-1:0] nib_sel;
  logic [MW-1:0] mult;

  for (genvar g = 0; g < NCODES; g++) begin : g_tab
    localparam int FD_BITS = BASE_BITS - STEP_BITS * g;
    localparam int HD_BITS = (g > HD_FLOOR_CODE) ?
                             (BASE_BITS - STEP_BITS * HD_FLOOR_CODE) : FD_BITS;
    assign fd_nib[g] = NW'(FD_BITS / BITS_PER_NIB);
    assign hd_nib[g] = NW'(HD_BITS / BITS_PER_NIB);
  end

  if (CYC_PER_NIB_10 == CYC_PER_NIB_100) begin : g_mul_same
    logic unused_speed;
    assign unused_speed = speed_i;
    assign mult = MW'(CYC_PER_NIB_10);
  end else begin : g_mul_sel
    assign mult = speed_i ? MW'(CYC_PER_NIB_100) : MW'(CYC_PER_NIB_10);
  end

  always_comb begin
    nib_sel  = half_i ? hd_nib[code_i] : fd_nib[code_i];
    cycles_o = CW'(nib_sel) * CW'(mult);
  end
endmodule

// File: rtl/ifg_gap_counter.sv
module ifg_gap_counter #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic [CW-1:0] remain_o
);
  always_ff @(posedge clk) begin
    if (rst)                  remain_o <= '0;
    else if (load_i)          remain_o <= load_val_i;
    else if (remain_o != '0)  remain_o <= remain_o - CW'(1);
  end
endmodule

// File: rtl/ifg_enforcer.sv
module ifg_enforcer
  import ifg_pkg::*;
#(
  parameter int BASE_BITS       = 96,
  parameter int STEP_BITS       = 8,
  parameter int HD_FLOOR_CODE   = 4,
  parameter int BITS_PER_NIB    = 4,
  parameter int CYC_PER_NIB_10  = 1,
  parameter int CYC_PER_NIB_100 = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [GAP_CODE_W-1:0] gap_code_i,
  input  logic                  half_duplex_i,
  input  logic                  speed_100_i,
  input  logic                  tx_en_i,
  input  logic                  tx_req_i,
  output logic                  grant_o
);
  localparam int MAX_MUL = (CYC_PER_NIB_10 > CYC_PER_NIB_100) ? CYC_PER_NIB_10 : CYC_PER_NIB_100;
  localparam int MAX_CYC = (BASE_BITS / BITS_PER_NIB) * MAX_MUL;
  localparam int CW      = $clog2(MAX_CYC + 1);

  logic          fall;
  logic [CW-1:0] gap_cycles;
  logic [CW-1:0] remain;
  logic          near_done;
  logic          grant_d;

  ifg_fall_detect u_fall (
    .clk    (clk),
    .rst    (rst),
    .en_i   (tx_en_i),
    .fall_o (fall)
  );

  ifg_gap_decode #(
    .BASE_BITS       (BASE_BITS),
    .STEP_BITS       (STEP_BITS),
    .HD_FLOOR_CODE   (HD_FLOOR_CODE),
    .BITS_PER_NIB    (BITS_PER_NIB),
    .CYC_PER_NIB_10  (CYC_PER_NIB_10),
    .CYC_PER_NIB_100 (CYC_PER_NIB_100),
    .CW              (CW)
  ) u_decode (
    .code_i   (gap_code_i),
    .half_i   (half_duplex_i),
    .speed_i  (speed_100_i),
    .cycles_o (gap_cycles)
  );

  // The fall edge is itself the first idle cycle, so load one less.
  ifg_gap_counter #(.CW(CW)) u_count (
    .clk        (clk),
    .rst        (rst),
    .load_i     (fall),
    .load_val_i (gap_cycles - CW'(1)),
    .remain_o   (remain)
  );

  assign near_done = (remain <= CW'(1));
  assign grant_d   = tx_req_i & ~tx_en_i & ~fall & near_done;

  always_ff @(posedge clk) begin
    if (rst) grant_o <= 1'b0;
    else     grant_o <= grant_d;
  end
endmodule

// File: rtl/ifg_enforcer_chk.sv
module ifg_enforcer_chk #(
  parameter int BASE_BITS       = 96,
  parameter int STEP_BITS       = 8,
  parameter int HD_FLOOR_CODE   = 4,
  parameter int BITS_PER_NIB    = 4,
  parameter int CYC_PER_NIB_10  = 1,
  parameter int CYC_PER_NIB_100 = 1
) (
  input logic       clk,
  input logic       rst,
  input logic [2:0] gap_code_i,
  input logic       half_duplex_i,
  input logic       speed_100_i,
  input logic       tx_en_i,
  input logic       tx_req_i,
  input logic       grant_o
);
  function automatic int want_cycles(input logic [2:0] c, input logic h, input logic s);
    int b;
    int fl;
    b  = BASE_BITS - STEP_BITS * int'(c);
    fl = BASE_BITS - STEP_BITS * HD_FLOOR_CODE;
    if (h && b < fl) b = fl;
    return (b / BITS_PER_NIB) * (s ? CYC_PER_NIB_100 : CYC_PER_NIB_10);
  endfunction

  logic prev_en;
  logic pending;
  logic rst_q;
  int   idle_cnt;
  int   exp_q;

  always_ff @(posedge clk) rst_q <= rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_en  <= 1'b0;
      pending  <= 1'b0;
      idle_cnt <= 0;
      exp_q    <= 0;
    end else begin
      prev_en <= tx_en_i;
      if (prev_en && !tx_en_i) begin
        pending  <= 1'b1;
        idle_cnt <= 1;
        exp_q    <= want_cycles(gap_code_i, half_duplex_i, speed_100_i);
      end else if (tx_en_i) begin
        pending <= 1'b0;
      end else if (pending && idle_cnt < 100000) begin
        idle_cnt <= idle_cnt + 1;
      end
    end
  end

  assert_gap_not_short_R4: assert property (@(posedge clk) disable iff (rst)
    (pending && $rose(grant_o)) |-> (idle_cnt >= exp_q));

  assert_quiet_in_frame_R5: assert property (@(posedge clk) disable iff (rst)
    tx_en_i |=> !grant_o);

  assert_grant_needs_req_R8: assert property (@(posedge clk) disable iff (rst)
    grant_o |-> $past(tx_req_i));

  assert_reset_clears_R9: assert property (@(posedge clk)
    rst_q |-> !grant_o);
endmodule

bind ifg_enforcer ifg_enforcer_chk #(
  .BASE_BITS       (BASE_BITS),
  .STEP_BITS       (STEP_BITS),
  .HD_FLOOR_CODE   (HD_FLOOR_CODE),
  .BITS_PER_NIB    (BITS_PER_NIB),
  .CYC_PER_NIB_10  (CYC_PER_NIB_10),
  .CYC_PER_NIB_100 (CYC_PER_NIB_100)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .gap_code_i    (gap_code_i),
  .half_duplex_i (half_duplex_i),
  .speed_100_i   (speed_100_i),
  .tx_en_i       (tx_en_i),
  .tx_req_i      (tx_req_i),
  .grant_o       (grant_o)
);

// File: tb/ifg_enforcer_tb_top.sv
module ifg_enforcer_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] gap_code;
  logic       half;
  logic       speed;
  logic       tx_en;
  logic       tx_req;
  logic       grant;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ifg_enforcer #(
    .CYC_PER_NIB_10  (3),
    .CYC_PER_NIB_100 (1)
  ) dut_i (
    .clk           (clk),
    .rst           (rst),
    .gap_code_i    (gap_code),
    .half_duplex_i (half),
    .speed_100_i   (speed),
    .tx_en_i       (tx_en),
    .tx_req_i      (tx_req),
    .grant_o       (grant)
  );

  // {code[2:0], half, speed, expected idle cycles[7:0]}; 10 Mb/s = 3 cycles/nibble
  localparam logic [12:0] VEC [16] = '{
    {3'd0, 1'b0, 1'b0, 8'd72}, {3'd1, 1'b0, 1'b1, 8'd22},
    {3'd2, 1'b0, 1'b0, 8'd60}, {3'd3, 1'b0, 1'b1, 8'd18},
    {3'd4, 1'b0, 1'b0, 8'd48}, {3'd5, 1'b0, 1'b1, 8'd14},
    {3'd6, 1'b0, 1'b0, 8'd36}, {3'd7, 1'b0, 1'b1, 8'd10},
    {3'd0, 1'b1, 1'b1, 8'd24}, {3'd1, 1'b1, 1'b0, 8'd66},
    {3'd2, 1'b1, 1'b1, 8'd20}, {3'd3, 1'b1, 1'b0, 8'd54},
    {3'd4, 1'b1, 1'b1, 8'd16}, {3'd5, 1'b1, 1'b0, 8'd48},
    {3'd6, 1'b1, 1'b1, 8'd16}, {3'd7, 1'b1, 1'b0, 8'd48}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Wait for grant, send a frame of len nibbles, drop tx_en (negedge aligned).
  task automatic send_frame(input int len);
    int w = 0;
    while (!grant && w < 2000) begin
      @(negedge clk);
      w++;
    end
    tx_en = 1'b1;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      check(grant == 1'b0, "R5", grant, 0);
    end
    tx_en = 1'b0;
  endtask

  // Count idle cycles until grant; optionally change config after chg cycles.
  task automatic measure(output int idle, input int chg,
                         input logic [2:0] c2, input logic h2, input logic s2);
    idle = 0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      idle++;
      if (idle == chg) begin
        gap_code = c2; half = h2; speed = s2;
      end
      if (grant) break;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int idle;
    rst = 1'b1; tx_req = 1'b1; tx_en = 1'b0;
    gap_code = 3'd0; half = 1'b0; speed = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(grant == 1'b0, "R9 reset", grant, 0);
    end
    rst = 1'b0;
    @(negedge clk);
    check(grant == 1'b1, "R7 no gap owed", grant, 1);
    tx_req = 1'b0;
    @(negedge clk);
    check(grant == 1'b0, "R8 req drop", grant, 0);
    tx_req = 1'b1;
    @(negedge clk);
    check(grant == 1'b1, "R8 req rise", grant, 1);

    // Table walk: all codes, both duplex modes, alternating speeds (R1 R2 R3 R4)
    for (int i = 0; i < 16; i++) begin
      gap_code = VEC[i][12:10];
      half     = VEC[i][9];
      speed    = VEC[i][8];
      send_frame(6);
      measure(idle, 0, 3'd0, 1'b0, 1'b0);
      if (half) check(idle == int'(VEC[i][7:0]), "R2 R3 R4 half gap", idle, int'(VEC[i][7:0]));
      else      check(idle == int'(VEC[i][7:0]), "R1 R3 R4 full gap", idle, int'(VEC[i][7:0]));
    end

    // R6: config change mid-gap does not alter current gap, applies to next
    gap_code = 3'd0; half = 1'b0; speed = 1'b1;
    send_frame(4);
    measure(idle, 3, 3'd7, 1'b0, 1'b1);
    check(idle == 24, "R6 gap held", idle, 24);
    send_frame(4);
    measure(idle, 0, 3'd0, 1'b0, 1'b0);
    check(idle == 10, "R6 next gap uses new code", idle, 10);

    // R8: request held low past the end of the gap
    send_frame(4);
    tx_req = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (grant) check(1'b0, "R8 no req no grant", grant, 0);
    end
    check(grant == 1'b0, "R8 grant idle without req", grant, 0);
    tx_req = 1'b1;
    @(negedge clk);
    check(grant == 1'b1, "R8 grant one cycle after req", grant, 1);

    // R9: reset during a gap abandons it
    gap_code = 3'd0; half = 1'b0; speed = 1'b0;
    send_frame(4);
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(grant == 1'b0, "R9 reset mid-gap", grant, 0);
    rst = 1'b0;
    @(negedge clk);
    check(grant == 1'b1, "R7 R9 gap dropped by reset", grant, 1);

    summary();
  end
endmodule